// File: doc/BRIEF.md
# Periodic trigger with retriggerable one-shot

This block produces a repeating timing pattern from a single clock. A wide period counter free-runs and, each time it reaches its terminal point, raises a trigger for exactly one cycle. That trigger acts as a synchronous enable for a narrow width counter. The width counter loads a programmed width and holds the pulse output high while it counts down. The pulse then stays low until the next trigger. The trigger is never used as a clock. Both counters share the one clock edge, and the trigger is taken on the first rising edge after it appears.

Two terminal detectors are available, and `detect_sel` picks one.

- **Carry mode** (`detect_sel` = 0): the detector watches for the all-ones count, which is the carry about to leave the counter. That same cycle reloads the counter and starts the pulse.
- **Edge mode** (`detect_sel` = 1): one extra flip-flop records the counter MSB. The detector fires on the MSB's falling edge, which is the cycle after the counter wraps to zero. This mode needs no wide compare, and its period is one cycle longer.

The period is set by a reload value. The counter counts upward from that value. Software writes the value with a one-cycle strobe.

Top module: `periodic_pulse_gen`

## Requirements
- R1: After a synchronous reset, `trigger_out` and `pulse_out` are 0, and the period counter and its reload value are both 0.
- R2: In carry mode (`detect_sel` = 0), with reload value L not all ones, `trigger_out` is high for exactly one cycle whenever the count is all ones. Consecutive triggers are 2^PERIOD_W − L cycles apart.
- R3: In edge mode (`detect_sel` = 1), `trigger_out` is high for one cycle when the count has just wrapped to 0, that is, when the registered MSB is 1 and the current MSB is 0. The counter then reloads, and consecutive triggers are 2^PERIOD_W − L + 1 cycles apart.
- R4: A trigger with width value N > 0 makes `pulse_out` go high on the next rising edge. The pulse stays high for exactly N cycles and then stays low until another trigger.
- R5: A trigger with width value 0 produces no pulse.
- R6: A trigger that arrives while a pulse is active restarts the count from the width value present with that trigger.
- R7: While `period_load` is high, `trigger_out` is forced low. On the next edge, both the count and the reload value take `period_value`, and the edge detector's MSB history is cleared. The first trigger after the load therefore follows one full period measured from the loaded value.
- R8: `width_value` is sampled only on the edge that follows a trigger. Changing it during a pulse does not change that pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| period_load | input | 1 | One-cycle strobe that writes `period_value` |
| period_value | input | PERIOD_W | Reload value; the counter counts upward from it |
| width_value | input | WIDTH_W | Pulse length in cycles, taken when a trigger occurs |
| detect_sel | input | 1 | Terminal detector: 0 = carry, 1 = MSB edge |
| trigger_out | output | 1 | One-cycle terminal trigger |
| pulse_out | output | 1 | High while the width counter is running |

## Verification
The assertions assume the following about the inputs:
- The reload value is never all ones while carry mode is selected. Such a value would make the trigger hold high and is outside the defined behaviour.
- `detect_sel` changes only while reset is held.

The stimulus respects both assumptions. It applies a reset before every change of mode. The reload values it sweeps all stay below all ones in carry mode. The width value changes only at a falling edge, away from the capture edge.

// File: rtl/ppg_pkg.sv
`timescale 1ns/1ps
package ppg_pkg;
  typedef enum logic {
    DET_CARRY    = 1'b0,
    DET_MSB_EDGE = 1'b1
  } det_mode_e;
endpackage

// File: rtl/ppg_period_ctr.sv
`timescale 1ns/1ps
// Loadable free-running up counter with a reload register.
module ppg_period_ctr #(
  parameter int PERIOD_W = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic [PERIOD_W-1:0] load_value,
  input  logic                term,
  output logic [PERIOD_W-1:0] count,
  output logic [PERIOD_W-1:0] reload
);
  logic [PERIOD_W-1:0] cnt_q;
  logic [PERIOD_W-1:0] reload_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (load) begin
      cnt_q    <= load_value;
      reload_q <= load_value;
    end else if (term) begin
      cnt_q    <= reload_q;
    end else begin
      cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign count  = cnt_q;
  assign reload = reload_q;
endmodule

// File: rtl/ppg_term_detect.sv
`timescale 1ns/1ps
// Two terminal detectors: the all-ones carry, and a registered MSB falling edge.
module ppg_term_detect
  import ppg_pkg::*;
#(
  parameter int PERIOD_W = 28
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  det_mode_e           mode,
  input  logic [PERIOD_W-1:0] count,
  output logic                term
);
  localparam int MSB = PERIOD_W - 1;

  logic msb_q;
  logic carry_hit;
  logic edge_hit;

  always_ff @(posedge clk) begin
    if (rst || clear) msb_q <= 1'b0;
    else              msb_q <= count[MSB];
  end

  assign carry_hit = &count;
  assign edge_hit  = msb_q & ~count[MSB];

  always_comb begin
    unique case (mode)
      DET_MSB_EDGE: term = edge_hit;
      default:      term = carry_hit;
    endcase
  end
endmodule

// File: rtl/ppg_width_ctr.sv
`timescale 1ns/1ps
// Retriggerable one-shot: loads the width on a start and counts down to zero.
module ppg_width_ctr #(
  parameter int WIDTH_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH_W-1:0] width,
  output logic               active
);
  logic [WIDTH_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst)                left_q <= '0;
    else if (start)         left_q <= width;
    else if (left_q != '0)  left_q <= left_q - 1'b1;
  end

  assign active = (left_q != '0);
endmodule

// File: rtl/periodic_pulse_gen.sv
`timescale 1ns/1ps
module periodic_pulse_gen
  import ppg_pkg::*;
#(
  parameter int PERIOD_W = 28,
  parameter int WIDTH_W  = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                period_load,
  input  logic [PERIOD_W-1:0] period_value,
  input  logic [WIDTH_W-1:0]  width_value,
  input  logic                detect_sel,
  output logic                trigger_out,
  output logic                pulse_out
);
  logic [PERIOD_W-1:0] count_w;
  logic [PERIOD_W-1:0] reload_q;
  logic                term_w;
  det_mode_e           mode_w;

  assign mode_w = det_mode_e'(detect_sel);

  ppg_period_ctr #(.PERIOD_W(PERIOD_W)) i_period (
    .clk        (clk),
    .rst        (rst),
    .load       (period_load),
    .load_value (period_value),
    .term       (term_w),
    .count      (count_w),
    .reload     (reload_q)
  );

  ppg_term_detect #(.PERIOD_W(PERIOD_W)) i_detect (
    .clk   (clk),
    .rst   (rst),
    .clear (period_load),
    .mode  (mode_w),
    .count (count_w),
    .term  (term_w)
  );

  // A load in progress suppresses the terminal event for that cycle.
  assign trigger_out = term_w & ~period_load;

  ppg_width_ctr #(.WIDTH_W(WIDTH_W)) i_width (
    .clk    (clk),
    .rst    (rst),
    .start  (trigger_out),
    .width  (width_value),
    .active (pulse_out)
  );
endmodule

// File: rtl/ppg_checker.sv
`timescale 1ns/1ps
module ppg_checker #(
  parameter int PERIOD_W = 28,
  parameter int WIDTH_W  = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                period_load,
  input logic [PERIOD_W-1:0] period_value,
  input logic [WIDTH_W-1:0]  width_value,
  input logic                detect_sel,
  input logic [PERIOD_W-1:0] reload,
  input logic                trigger_out,
  input logic                pulse_out
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!trigger_out && !pulse_out));

  // R2
  single_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    (trigger_out && (detect_sel || !(&reload))) |=> !trigger_out);

  // R3
  edge_mode_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (trigger_out && detect_sel) |=> !trigger_out);

  // R4
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    (trigger_out && width_value != '0) |=> pulse_out);

  // R4
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pulse_out) |-> !$past(trigger_out));

  // R5
  zero_width_chk: assert property (@(posedge clk) disable iff (rst)
    (trigger_out && width_value == '0) |=> !pulse_out);

  // R7
  load_no_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    (period_load && (detect_sel || !(&period_value))) |=> !trigger_out);
endmodule

bind periodic_pulse_gen ppg_checker #(.PERIOD_W(PERIOD_W), .WIDTH_W(WIDTH_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .period_load  (period_load),
  .period_value (period_value),
  .width_value  (width_value),
  .detect_sel   (detect_sel),
  .reload       (reload_q),
  .trigger_out  (trigger_out),
  .pulse_out    (pulse_out)
);

// File: tb/test_periodic_pulse_gen.sv
`timescale 1ns/1ps
module test_periodic_pulse_gen;
  localparam int PW   = 5;
  localparam int WW   = 3;
  localparam int FULL = 1 << PW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          period_load = 1'b0;
  logic [PW-1:0] period_value = '0;
  logic [WW-1:0] width_value = '0;
  logic          detect_sel = 1'b0;
  logic          trigger_out;
  logic          pulse_out;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  periodic_pulse_gen #(.PERIOD_W(PW), .WIDTH_W(WW)) i_periodic_pulse_gen (
    .clk(clk), .rst(rst), .period_load(period_load), .period_value(period_value),
    .width_value(width_value), .detect_sel(detect_sel),
    .trigger_out(trigger_out), .pulse_out(pulse_out)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input bit mode, input int n);
    @(negedge clk);
    rst = 1'b1; detect_sel = mode; width_value = WW'(n); period_load = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(trigger_out == 1'b0 && pulse_out == 1'b0, "R1", "outputs after reset",
        int'({trigger_out, pulse_out}), 0);
  endtask

  // Load L at cycle 0, then observe three full periods.
  task automatic sweep_case(input bit mode, input int l, input int n);
    int p, last, trig_n, hi;
    string rq;
    p  = mode ? FULL - l + 1 : FULL - l;
    rq = mode ? "R3" : "R2";
    do_reset(mode, n);
    @(negedge clk);
    period_load = 1'b1; period_value = PW'(l);
    #1;
    chk(trigger_out == 1'b0, "R7", "trigger during load", int'(trigger_out), 0);
    last = 0; trig_n = 0; hi = 0;
    for (int c = 1; c <= 3 * p; c++) begin
      @(negedge clk);
      period_load = 1'b0;
      #1;
      if (pulse_out) hi++;
      if (trigger_out) begin
        trig_n++;
        chk(c - last == p, rq, "trigger interval", c - last, p);
        if (trig_n > 1)
          chk(hi == ((n < p) ? n : p), (n == 0) ? "R5" : ((n > p) ? "R6" : "R4"),
              "pulse cycles per period", hi, (n < p) ? n : p);
        last = c; hi = 0;
      end
    end
    chk(trig_n == 3, rq, "trigger count", trig_n, 3);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lv[6] = '{0, 3, 16, 25, 29, 30};
    int hi, trig_seen;
    for (int m = 0; m < 2; m++)
      for (int i = 0; i < 6; i++)
        for (int n = 0; n < (1 << WW); n++)
          sweep_case(m[0], lv[i], n);

    // R7: load lands in the cycle the carry terminal would fire.
    do_reset(1'b0, 3);
    @(negedge clk);
    period_load = 1'b1; period_value = PW'(20);      // trigger due at cycle 12
    @(negedge clk);
    period_load = 1'b0;
    for (int c = 2; c <= 12; c++) @(negedge clk);
    period_load = 1'b1; period_value = PW'(10);
    #1;
    chk(trigger_out == 1'b0, "R7", "trigger masked by load", int'(trigger_out), 0);
    trig_seen = 0;
    for (int c = 13; c <= 34; c++) begin
      @(negedge clk);
      period_load = 1'b0;
      #1;
      if (c == 13) chk(pulse_out == 1'b0, "R7", "no pulse from masked trigger", int'(pulse_out), 0);
      if (trigger_out && trig_seen == 0) begin
        trig_seen = c;
      end
    end
    chk(trig_seen == 34, "R7", "first trigger after reload", trig_seen, 34);

    // R8: width changed during a pulse has no effect on that pulse.
    do_reset(1'b0, 5);
    @(negedge clk);
    period_load = 1'b1; period_value = PW'(20);
    @(negedge clk);
    period_load = 1'b0;
    for (int c = 2; c <= 12; c++) @(negedge clk);
    #1;
    chk(trigger_out == 1'b1, "R2", "trigger at terminal", int'(trigger_out), 1);
    hi = 0;
    for (int c = 13; c <= 20; c++) begin
      @(negedge clk);
      if (c == 13) width_value = WW'(1);
      #1;
      if (pulse_out) hi++;
    end
    chk(hi == 5, "R8", "pulse length after width change", hi, 5);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule